// File: doc/BRIEF.md
# Carrier Loop Error Output Stage

This block takes the signed phase error word of a carrier recovery loop and sends it off chip toward an external loop filter and oscillator. The block has two output modes, selected by a configuration register.

In the default mode, a first-order sigma-delta modulator turns the error word into a 1-bit stream. That stream drives two complementary pad pairs. Each pair has its own active-low enable. An external analog integrator sums the two pairs with different resistor and capacitor weights. Enabling one pair, the other, or both therefore sets the loop bandwidth across a wide range of symbol rates.

At low symbol rates, roughly one to five Mbaud, the modulator delay makes the loop too narrow. For that case a select bit silences both pairs and presents the error word on parallel pins in offset binary, for an external DAC. A clock-select bit replaces the normal data-valid output with a sample clock for that DAC. The clock rises one cycle after each new word, so the word is already stable at the DAC's sampling edge.

Every pad is modelled as a data line plus an output-enable line. A low enable means the pad is in high impedance.

Top module: `carrier_err_out`

## Requirements
- R1: After reset the configuration register holds 000000. Both pairs are enabled (`sd_oe` = 11), `ped_oe` is 0, `ped_out` is 100000, and `dvalid_out` follows `dvalid_in`.
- R2: While a pair's `sd_oe` bit is 1, its `sd_p` line equals the modulator bit and its `sd_n` line carries the inverse.
- R3: Configuration bit 4 is the active-low enable of pair 0, and bit 5 is the active-low enable of pair 1. A disabled pair has `sd_oe` = 0 and holds both of its lines at 0 (high impedance at the pad).
- R4: A word sampled with `err_valid` appears on `ped_out` after one clock edge as offset binary, which is the two's-complement word with its top bit inverted. For example, -32 gives 000000, 0 gives 100000, and +31 gives 111111.
- R5: While `err_valid` is low, `ped_out` holds its value, whatever `err_in` does.
- R6: With a constant code C on `ped_out`, the bitstream carries exactly C ones in any window of 64 consecutive clocks.
- R7: When output-select bit 0 is 1, both pairs are disabled regardless of bits [5:4]. `ped_oe` is 1 only when bit 0 and parallel-enable bit 1 are both 1.
- R8: When clock-select bit 2 is 1, `dvalid_out` carries the DAC clock. The clock goes high one edge after the word update and low on the edge after that. When bit 2 is 0, `dvalid_out` equals `dvalid_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the modulator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 6 | Configuration register write data |
| err_valid | input | 1 | New error sample strobe |
| err_in | input | 6 | Signed phase error word |
| dvalid_in | input | 1 | Normal data-valid signal for the shared pin |
| sd_p | output | 2 | True line of each modulator pair |
| sd_n | output | 2 | Inverted line of each modulator pair |
| sd_oe | output | 2 | Pad enable of each modulator pair |
| ped_out | output | 6 | Offset binary error word for the external DAC |
| ped_oe | output | 1 | Pad enable of the parallel word |
| dvalid_out | output | 1 | Shared pin: data-valid or DAC sample clock |

## Verification
The assertions check four properties on every cycle:
- enabled pairs stay complementary;
- disabled pairs stay quiet;
- the parallel mode never overlaps the modulator pairs;
- each sampled word maps to offset binary and then holds between samples.

Three things can only be shown by the bench's directed scenarios:
- the register decoding of all four pair-enable combinations and the reset defaults;
- the exact ones count over a 64-clock window at the extreme and mid-scale codes;
- the placement of the DAC clock pulse relative to the word update.

// File: rtl/cerr_pkg.sv
// Shared constants and types for the carrier loop error output stage.
// Assumes two modulator pairs and a six-bit configuration register.
package cerr_pkg;
    localparam int NUM_PAIRS    = 2;
    localparam int CFG_W        = 6;
    localparam int BIT_OUT_SEL  = 0;   // parallel word replaces the pairs
    localparam int BIT_PAR_EN   = 1;   // parallel pads driven
    localparam int BIT_DAC_CLK  = 2;   // DAC clock on shared pin
    localparam int BIT_PAIR_DIS = 4;   // [5:4] active-low pair enables

    typedef struct packed {
        logic [NUM_PAIRS-1:0] pair_dis;
        logic                 dac_clk_sel;
        logic                 par_en;
        logic                 out_sel;
    } cerr_cfg_t;
endpackage

// File: rtl/cerr_cfg_reg.sv
// Configuration register for the error output stage.
// Holds the mode fields; reset value is all zero (both pairs on).
// Assumes a write strobe synchronous to clk; no read path is needed.
module cerr_cfg_reg
    import cerr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output cerr_cfg_t        cfg
);
    logic unused_cfg_bit;
    assign unused_cfg_bit = wdata[3];

    // Capture the decoded fields on a write, clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (we) begin
            cfg.out_sel     <= wdata[BIT_OUT_SEL];
            cfg.par_en      <= wdata[BIT_PAR_EN];
            cfg.dac_clk_sel <= wdata[BIT_DAC_CLK];
            cfg.pair_dis    <= wdata[BIT_PAIR_DIS +: NUM_PAIRS];
        end
    end
endmodule

// File: rtl/cerr_offset_reg.sv
// Converts the signed error word to offset binary and registers it on
// each new sample, so it stays steady until the next one. Also makes a
// one-cycle DAC clock pulse that rises one edge after the word update.
// Assumes err_valid pulses have at least one idle cycle between them
// when the DAC clock is in use.
module cerr_offset_reg #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         err_valid,
    input  logic [W-1:0] err_in,
    output logic [W-1:0] code_q,
    output logic         dac_clk_q
);
    localparam logic [W-1:0] MID_CODE = {1'b1, {(W-1){1'b0}}};

    logic pend_q;

    // Register the offset binary word on each valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n)         code_q <= MID_CODE;
        else if (err_valid) code_q <= {~err_in[W-1], err_in[W-2:0]};
    end

    // Delay the sample strobe twice to place the DAC clock after the update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            dac_clk_q <= 1'b0;
        end else begin
            pend_q    <= err_valid;
            dac_clk_q <= pend_q;
        end
    end
endmodule

// File: rtl/cerr_sigma_delta.sv
// First-order sigma-delta modulator. The residue plus the code produces
// a carry, and that carry is the registered bitstream. Ones density is
// code / 2**W, exact over any 2**W consecutive clocks.
// Assumes the code is held constant by the caller between samples.
module cerr_sigma_delta #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] code,
    output logic         bit_q
);
    logic [W-1:0] acc_q;
    logic [W:0]   sum;

    assign sum = {1'b0, acc_q} + {1'b0, code};

    // Advance the residue and register the carry on every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            bit_q <= 1'b0;
        end else begin
            acc_q <= sum[W-1:0];
            bit_q <= sum[W];
        end
    end
endmodule

// File: rtl/carrier_err_out.sv
// Carrier loop error output stage (top). Drives the error either as a
// sigma-delta bitstream on individually enabled complementary pairs, or
// as a parallel offset binary word with a DAC sample clock.
// Assumes pads are built outside: data plus active-high output enable.
module carrier_err_out
    import cerr_pkg::*;
#(
    parameter int ERR_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic                 err_valid,
    input  logic [ERR_W-1:0]     err_in,
    input  logic                 dvalid_in,
    output logic [NUM_PAIRS-1:0] sd_p,
    output logic [NUM_PAIRS-1:0] sd_n,
    output logic [NUM_PAIRS-1:0] sd_oe,
    output logic [ERR_W-1:0]     ped_out,
    output logic                 ped_oe,
    output logic                 dvalid_out
);
    cerr_cfg_t        cfg;
    logic [ERR_W-1:0] code_q;
    logic             dac_clk_q;
    logic             sd_bit;

    cerr_cfg_reg i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    cerr_offset_reg #(.W(ERR_W)) i_word (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_valid (err_valid),
        .err_in    (err_in),
        .code_q    (code_q),
        .dac_clk_q (dac_clk_q)
    );

    cerr_sigma_delta #(.W(ERR_W)) i_mod (
        .clk   (clk),
        .rst_n (rst_n),
        .code  (code_q),
        .bit_q (sd_bit)
    );

    // One pad pair per generate step; quiet lines when disabled.
    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
        logic pair_on;
        assign pair_on  = ~cfg.out_sel & ~cfg.pair_dis[i];
        assign sd_oe[i] = pair_on;
        assign sd_p[i]  = pair_on & sd_bit;
        assign sd_n[i]  = pair_on & ~sd_bit;
    end

    // Parallel word pads and the shared data-valid pin.
    assign ped_out    = code_q;
    assign ped_oe     = cfg.out_sel & cfg.par_en;
    assign dvalid_out = cfg.dac_clk_sel ? dac_clk_q : dvalid_in;
endmodule

// File: rtl/cerr_checker.sv
// Property checker for carrier_err_out, attached by bind below.
// Assumes the default six-bit error word and two pairs.
module cerr_checker
    import cerr_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 err_valid,
    input logic [5:0]           err_in,
    input logic [NUM_PAIRS-1:0] sd_p,
    input logic [NUM_PAIRS-1:0] sd_n,
    input logic [NUM_PAIRS-1:0] sd_oe,
    input logic [5:0]           ped_out,
    input logic                 ped_oe
);
    assert_pair_complement_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((sd_p ^ sd_n) & sd_oe) == sd_oe);

    assert_pair_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((sd_p | sd_n) & ~sd_oe) == '0);

    assert_bypass_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ped_oe |-> (sd_oe == '0));

    assert_word_map_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |=> (ped_out == {~$past(err_in[5]), $past(err_in[4:0])}));

    assert_word_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !err_valid |=> $stable(ped_out));
endmodule

bind carrier_err_out cerr_checker i_cerr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_valid (err_valid),
    .err_in    (err_in),
    .sd_p      (sd_p),
    .sd_n      (sd_n),
    .sd_oe     (sd_oe),
    .ped_out   (ped_out),
    .ped_oe    (ped_oe)
);

// File: tb/test_carrier_err_out.sv
module test_carrier_err_out;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [5:0] cfg_wdata = '0;
    logic       err_valid = 1'b0;
    logic [5:0] err_in = '0;
    logic       dvalid_in = 1'b0;
    logic [1:0] sd_p, sd_n, sd_oe;
    logic [5:0] ped_out;
    logic       ped_oe, dvalid_out;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    carrier_err_out i_carrier_err_out (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .err_valid(err_valid), .err_in(err_in), .dvalid_in(dvalid_in),
        .sd_p(sd_p), .sd_n(sd_n), .sd_oe(sd_oe), .ped_out(ped_out),
        .ped_oe(ped_oe), .dvalid_out(dvalid_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic write_cfg(input logic [5:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic send_err(input logic [5:0] e);
        err_valid = 1'b1; err_in = e;
        step();
        err_valid = 1'b0;
    endtask

    // R1: defaults right after reset
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check(sd_oe == 2'b11, "R1 sd_oe", sd_oe, 3);
        check(ped_oe == 1'b0, "R1 ped_oe", ped_oe, 0);
        check(ped_out == 6'h20, "R1 ped_out", ped_out, 32);
        dvalid_in = 1'b1; #1;
        check(dvalid_out == 1'b1, "R1 dvalid pass", dvalid_out, 1);
        dvalid_in = 1'b0; #1;
        check(dvalid_out == 1'b0, "R1 dvalid pass", dvalid_out, 0);
    endtask

    // R2 and R3: all four pair enable combinations
    task automatic t_pairs();
        for (int v = 0; v < 4; v++) begin
            write_cfg(6'(v << 4));
            check(sd_oe == 2'(~v), "R3 sd_oe", sd_oe, (~v) & 3);
            for (int k = 0; k < 4; k++) begin
                for (int i = 0; i < 2; i++) begin
                    if (v[i]) check((sd_p[i] | sd_n[i]) == 1'b0, "R3 quiet", {sd_p[i], sd_n[i]}, 0);
                    else      check(sd_p[i] != sd_n[i], "R2 complement", {sd_p[i], sd_n[i]}, 1);
                end
                step();
            end
        end
        write_cfg(6'h00);
    endtask

    // R4: offset binary mapping at the extremes and at zero
    task automatic t_map();
        send_err(6'h20);
        check(ped_out == 6'h00, "R4 min", ped_out, 0);
        send_err(6'h00);
        check(ped_out == 6'h20, "R4 zero", ped_out, 32);
        send_err(6'h1F);
        check(ped_out == 6'h3F, "R4 max", ped_out, 63);
        send_err(6'h3F);
        check(ped_out == 6'h1F, "R4 minus one", ped_out, 31);
    endtask

    // R5: word ignores err_in while err_valid is low
    task automatic t_hold();
        send_err(6'h05);
        err_in = 6'h3A;
        repeat (3) step();
        check(ped_out == 6'h25, "R5 hold", ped_out, 37);
    endtask

    // R6: ones count over 64 clocks equals the code
    task automatic t_density(input logic [5:0] e);
        int ones = 0;
        int exp_code = int'({~e[5], e[4:0]});
        send_err(e);
        for (int k = 0; k < 64; k++) begin
            step();
            ones += int'(sd_p[0]);
        end
        check(ones == exp_code, "R6 density", ones, exp_code);
    endtask

    // R7: parallel select and enable
    task automatic t_bypass();
        write_cfg(6'b110001);
        check(sd_oe == 2'b00, "R7 pairs off", sd_oe, 0);
        check(ped_oe == 1'b0, "R7 par disabled", ped_oe, 0);
        write_cfg(6'b000011);
        check(sd_oe == 2'b00, "R7 pairs off", sd_oe, 0);
        check(ped_oe == 1'b1, "R7 par driven", ped_oe, 1);
        write_cfg(6'b000010);
        check(ped_oe == 1'b0, "R7 sel low", ped_oe, 0);
        check(sd_oe == 2'b11, "R7 pairs back", sd_oe, 3);
    endtask

    // R8: DAC clock placement and pass-through when deselected
    task automatic t_dac_clk();
        write_cfg(6'b000111);
        dvalid_in = 1'b1;
        step();
        check(dvalid_out == 1'b0, "R8 idle", dvalid_out, 0);
        send_err(6'h11);
        check(dvalid_out == 1'b0, "R8 before rise", dvalid_out, 0);
        step();
        check(dvalid_out == 1'b1, "R8 high", dvalid_out, 1);
        check(ped_out == 6'h31, "R8 word stable", ped_out, 49);
        step();
        check(dvalid_out == 1'b0, "R8 low", dvalid_out, 0);
        write_cfg(6'b000000);
        check(dvalid_out == 1'b1, "R8 pass", dvalid_out, 1);
        dvalid_in = 1'b0;
    endtask

    initial begin
        t_reset();
        t_pairs();
        t_map();
        t_hold();
        t_density(6'h20);
        t_density(6'h00);
        t_density(6'h1F);
        t_density(6'h0A);
        t_bypass();
        t_dac_clk();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule